// File: doc/BRIEF.md
# Legacy Interrupt and Message-Pending Status Collector

This block gathers the four level-sensitive legacy interrupt lines of a PCIe root port (A, B, C and D) and a single "message interrupt waiting" level into one 32-bit status word. A second word with the same bit layout holds a per-source enable. The block drives one interrupt request to the host processor. That request is high whenever any source is both recorded in the status word and enabled.

Software works through a plain register port. A read returns the selected word combinationally. A write to the status word clears every bit written as one and leaves bits written as zero alone. A write to the enable word loads the enable of every source, which masks or unmasks it. A source whose line is still high when its status bit is cleared sets that bit again, so level interrupts cannot be lost. The legacy lines occupy four neighbouring status bits starting at `INTX_LSB` (default 5), in the order A, B, C, D. The message-pending source has its own bit at `MSI_POS` (default 3).

Top module: `irq_agg_top`

## Requirements
- R1: After reset the status word, the enable word and `irq` are all zero.
- R2: While legacy line n (n = 0 for A up to 3 for D) is high at a rising clock edge, status bit `INTX_LSB`+n (bits 5..8 by default) is one after that edge.
- R3: While `msi_pend` is high at a rising clock edge, status bit `MSI_POS` (bit 3 by default) is one after that edge.
- R4: A write to the status word (address 0x0) clears each source bit written as one. Source bits written as zero keep their value. Status bits are not cleared in any other way.
- R5: When a source input is high in the same cycle as a clear of its bit, the bit stays one. The set takes priority over the clear.
- R6: A write to the enable word (address 0x4) loads every source enable bit from the matching write-data bit. The enable word reads back with the same layout.
- R7: `irq` is a register. It is one in the cycle after any bit is set in both status and enable, and zero in the cycle after no such bit remains.
- R8: A source whose enable bit is zero still records in the status word but cannot raise `irq`.
- R9: Bits that belong to no source read as zero in both words, whatever was written to them. Any address other than 0x0 and 0x4 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 4 | Byte address of the word (0x0 status, 0x4 enable) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| intx_lvl | input | 4 | Legacy interrupt levels, bit 0 = line A |
| msi_pend | input | 1 | Message interrupt pending level |
| irq | output | 1 | Combined interrupt request to the host |

## Verification
A source level that is high at edge k shows in the status read right after edge k. `irq` follows one edge later, at k+1. A clear written across edge k takes effect in the status read after k, and `irq` drops after edge k+1. Writes to the enable word follow the same timing. The bench drives every input on the falling edge and samples on the next falling edge. That falling edge comes after the edge where the status is due, so each check falls in its due cycle. The bench also checks that `irq` is still unchanged one falling edge early, which catches an extra or a missing register stage.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int NUM_INTX = 4;
  localparam int NUM_SRC  = NUM_INTX + 1;

  // next value of a sticky status bit: a live level wins over a clear
  function automatic logic stat_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // bit position of source idx in the status/enable words
  function automatic int src_pos(int idx, int intx_lsb, int msi_pos);
    return (idx < NUM_INTX) ? (intx_lsb + idx) : msi_pos;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_d_i,
  output logic stat_o,
  output logic en_o,
  output logic pend_o
);

  logic stat_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      stat_q <= stat_next(stat_q, src_i, clr_i);
      if (en_wr_i) en_q <= en_d_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = stat_q & en_q;

  assert_src_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_i |=> stat_q);

  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i && clr_i) |=> stat_q);

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !src_i) |=> !stat_q);

  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_i) |=> stat_q);

  assert_enable_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> (en_q == $past(en_d_i)));

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               irq_o
);

  logic any_pend;
  logic irq_q;

  assign any_pend = |pend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pend;
  end

  assign irq_o = irq_q;

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> irq_q);

  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !irq_q);

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int INTX_LSB = 5,
  parameter int MSI_POS  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [3:0]        intx_lvl,
  input  logic              msi_pend,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(4);

  function automatic logic [DATA_W-1:0] used_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[src_pos(i, INTX_LSB, MSI_POS)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] USED_MASK = used_mask();

  logic [NUM_SRC-1:0] src_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] en_d_vec;
  logic [NUM_SRC-1:0] stat_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic [DATA_W-1:0]  stat_word;
  logic [DATA_W-1:0]  en_word;
  logic               stat_wr;
  logic               en_wr;
  logic [DATA_W-1:0]  unused_wdata;

  assign src_vec      = {msi_pend, intx_lvl};
  assign stat_wr      = reg_wr_en && (reg_addr == ADDR_STAT);
  assign en_wr        = reg_wr_en && (reg_addr == ADDR_EN);
  assign unused_wdata = reg_wdata & ~USED_MASK;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      clr_vec[i]  = stat_wr & reg_wdata[src_pos(i, INTX_LSB, MSI_POS)];
      en_d_vec[i] = reg_wdata[src_pos(i, INTX_LSB, MSI_POS)];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src_vec[g]),
      .clr_i   (clr_vec[g]),
      .en_wr_i (en_wr),
      .en_d_i  (en_d_vec[g]),
      .stat_o  (stat_vec[g]),
      .en_o    (en_vec[g]),
      .pend_o  (pend_vec[g])
    );
  end

  always_comb begin
    stat_word = '0;
    en_word   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      stat_word[src_pos(i, INTX_LSB, MSI_POS)] = stat_vec[i];
      en_word[src_pos(i, INTX_LSB, MSI_POS)]   = en_vec[i];
    end
  end

  always_comb begin
    if (reg_addr == ADDR_STAT)    reg_rdata = stat_word;
    else if (reg_addr == ADDR_EN) reg_rdata = en_word;
    else                          reg_rdata = '0;
  end

  irq_out_reg #(.NUM_SRC(NUM_SRC)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_vec),
    .irq_o  (irq)
  );

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~USED_MASK) == '0);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_word & en_word) == '0) |=> !irq);

endmodule

// File: tb/tb_irq_agg_top.sv
`timescale 1ns/1ps
module tb_irq_agg_top;

  localparam int DATA_W = 32;
  localparam int INTX0  = 5;
  localparam int MSIB   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  intx_lvl = 4'h0;
  logic        msi_pend = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intx_lvl(intx_lvl),
    .msi_pend(msi_pend), .irq(irq)
  );

  // expected bit for a source, restated from the requirements
  function automatic logic [31:0] bit_of(int idx);
    if (idx < 4) return 32'h1 << (INTX0 + idx);
    return 32'h1 << MSIB;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  // write spans one rising edge; returns at the following falling edge
  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 status", d, 0);
    rd(4'h4, d); chk("R1 enable", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_intx_each();
    logic [31:0] d;
    for (int n = 0; n < 4; n++) begin
      intx_lvl = 4'h1 << n;
      @(negedge clk);
      rd(4'h0, d); chk("R2 line set", d, bit_of(n));
      intx_lvl = 4'h0;
      @(negedge clk);
      rd(4'h0, d); chk("R4 sticky after release", d, bit_of(n));
      chk("R8 disabled no irq", {31'd0, irq}, 0);
      wr(4'h0, bit_of(n));
      rd(4'h0, d); chk("R4 cleared", d, 0);
    end
  endtask

  task automatic t_msi();
    logic [31:0] d;
    msi_pend = 1'b1;
    @(negedge clk);
    msi_pend = 1'b0;
    rd(4'h0, d); chk("R3 msi bit", d, bit_of(4));
    wr(4'h0, bit_of(4));
    rd(4'h0, d); chk("R3 msi cleared", d, 0);
  endtask

  task automatic t_partial_clear();
    logic [31:0] d;
    intx_lvl = 4'b0101;
    @(negedge clk);
    intx_lvl = 4'h0;
    wr(4'h0, bit_of(0));
    rd(4'h0, d); chk("R4 zero bits kept", d, bit_of(2));
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R4 all cleared", d, 0);
  endtask

  task automatic t_level_hold();
    logic [31:0] d;
    intx_lvl = 4'b0010;
    @(negedge clk);
    wr(4'h0, bit_of(1));
    rd(4'h0, d); chk("R5 set beats clear", d, bit_of(1));
    intx_lvl = 4'h0;
    wr(4'h0, bit_of(1));
    rd(4'h0, d); chk("R5 clears after release", d, 0);
  endtask

  task automatic t_enable_map();
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R6 enable readback", d, 32'h0000_01E8);
    wr(4'h4, 32'h0000_00A0);
    rd(4'h4, d); chk("R6 enable partial", d, 32'h0000_00A0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R9 unmapped reads zero", d, 0);
    intx_lvl = 4'hF; msi_pend = 1'b1;
    @(negedge clk);
    intx_lvl = 4'h0; msi_pend = 1'b0;
    rd(4'h0, d); chk("R9 status unused zero", d, 32'h0000_01E8);
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h4, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_irq_timing();
    wr(4'h4, 32'hFFFF_FFFF);
    intx_lvl = 4'b1000;
    @(negedge clk);
    chk("R7 irq one cycle late", {31'd0, irq}, 0);
    intx_lvl = 4'h0;
    @(negedge clk);
    chk("R7 irq rises", {31'd0, irq}, 1);
    wr(4'h0, bit_of(3));
    chk("R7 irq held one cycle", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R7 irq falls", {31'd0, irq}, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4'h4, bit_of(4));
    intx_lvl = 4'b0001;
    @(negedge clk);
    intx_lvl = 4'h0;
    repeat (2) @(negedge clk);
    chk("R8 masked line quiet", {31'd0, irq}, 0);
    rd(4'h0, d); chk("R8 masked still recorded", d, bit_of(0));
    msi_pend = 1'b1;
    @(negedge clk);
    msi_pend = 1'b0;
    @(negedge clk);
    chk("R7 msi raises irq", {31'd0, irq}, 1);
    wr(4'h0, bit_of(4));
    @(negedge clk);
    chk("R8 masked pending ignored", {31'd0, irq}, 0);
    wr(4'h4, bit_of(0));
    @(negedge clk);
    chk("R6 unmask raises irq", {31'd0, irq}, 1);
    wr(4'h4, 32'h0);
    @(negedge clk);
    chk("R8 remask drops irq", {31'd0, irq}, 0);
    wr(4'h0, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_intx_each();
    t_msi();
    t_partial_clear();
    t_level_hold();
    t_enable_map();
    t_irq_timing();
    t_mask();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog got=running exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule